// File: doc/BRIEF.md
# Erased Sector Zero-Bit Detector

When the error-correction decoder of a NAND flash controller gives up on a sector (it reports more errors than it can fix), the sector may still be healthy: it may simply be a freshly erased sector. Every cell of such a sector reads as one. The stored parity of an all-ones sector is not all-ones, so the decoder rejects it. This block settles the question. It reads the sector's 512 data bytes, then its 13 parity bytes, as a byte stream. It counts the bits that read as zero in each of the two regions, and stops counting a region once its total passes the correction limit of 8.

At the end of the stream it gives a verdict, held until the next sector starts. The sector is either erased, reported with the number of flipped bits, or uncorrectable. When the sector is erased and some of the flipped bits lie in the data region, the block also requests that the data bytes be overwritten with all-ones. The verdict is computed only when the decoder's error count, sampled at the start pulse, is above the limit. For any other sector the bytes are passed over and the verdict reports nothing.

Top module: `erased_sector_detect`

## Requirements
- R1: After a start pulse, accepted bytes 0 to 511 belong to the data region and bytes 512 to 524 to the parity region. Bytes after index 524 are not counted, and a byte with byte_valid_i low is never taken.
- R2: Each counted byte adds its number of zero bits (8 minus its population count) to the total of its region.
- R3: Each region's total saturates at 9 (limit plus one) and never wraps, however many zero bits follow.
- R4: When the data total plus the parity total is at most 8, the verdict is erased_o=1 and uncorrectable_o=0, and flips_o equals that sum.
- R5: When the sum exceeds 8, the verdict is uncorrectable_o=1, erased_o=0 and flips_o=0.
- R6: force_ones_o is 1 only for an erased verdict whose data total is non-zero. An erased verdict with zero bits only in parity leaves it 0.
- R7: The check is armed only when dec_err_i, sampled with start_i, is greater than 8. An unarmed sector still gives a done pulse, with erased_o, uncorrectable_o, force_ones_o and flips_o all 0.
- R8: done_o is a one-cycle pulse in the cycle after the clock edge that takes the byte marked byte_last_i. The verdict outputs stay unchanged from then on until the next start pulse, including while stray bytes arrive.
- R9: A start pulse clears all totals, the byte index and the verdict: in the next cycle every output is 0. A sector cut short by a new start pulse leaves nothing behind.
- R10: After reset, done_o, erased_o, uncorrectable_o, force_ones_o and flips_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new sector and clears all state |
| dec_err_i | input | 4 | Decoder error count for the sector, sampled with start_i |
| byte_valid_i | input | 1 | byte_i carries a sector byte this cycle |
| byte_i | input | 8 | Sector byte: data first, then parity |
| byte_last_i | input | 1 | Marks the final byte of the sector |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| erased_o | output | 1 | The sector is an erased sector |
| uncorrectable_o | output | 1 | The sector has too many zero bits to be erased |
| force_ones_o | output | 1 | The data bytes must be overwritten with all-ones |
| flips_o | output | 5 | Number of flipped bits on an erased verdict |

## Verification
On every cycle the assertions check the following:
- Each region total stays at or below 9 and never falls between start pulses.
- The byte index never runs past the end of the sector.
- erased and uncorrectable are never raised together.
- force_ones_o only appears with erased.
- An erased count never exceeds 8.
- done_o lasts one cycle, and the verdict holds still between results.
- A start pulse clears the outputs in the following cycle.

Only the bench's scenarios can show that the arithmetic is right. These include the split between data and parity at byte 511/512, the boundary sums of 8 and 9, saturation under all-zero data, bytes past the parity region, idle cycles inside the stream, a restart in the middle of a sector, and unarmed sectors.

// File: rtl/esd_pkg.sv
package esd_pkg;

  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_DATA   = 2'd1,
    RG_PARITY = 2'd2
  } region_e;

  // Number of bits that read as zero in one byte.
  function automatic int unsigned zero_bits(input logic [7:0] b);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      if (!b[k]) n++;
    end
    return n;
  endfunction

  // Addition that stops at a ceiling; once at the ceiling it stays there.
  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned cap);
    int unsigned s;
    s = a + b;
    return (s > cap) ? cap : s;
  endfunction

endpackage

// File: rtl/esd_sequencer.sv
module esd_sequencer
  import esd_pkg::*;
#(
  parameter int DATA_BYTES   = 512,
  parameter int PARITY_BYTES = 13,
  parameter int ERR_W        = 4,
  parameter int LIMIT        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ERR_W-1:0] dec_err_i,
  input  logic             valid_i,
  input  logic             last_i,
  output region_e          region_o,
  output logic             take_o,
  output logic             last_take_o,
  output logic             armed_o
);
  localparam int TOTAL = DATA_BYTES + PARITY_BYTES;
  localparam int IDX_W = $clog2(TOTAL + 1);
  localparam logic [IDX_W-1:0] IDX_DATA_END = IDX_W'(DATA_BYTES);
  localparam logic [IDX_W-1:0] IDX_END      = IDX_W'(TOTAL);

  logic             busy_q, armed_q;
  logic [IDX_W-1:0] idx_q;

  assign take_o      = busy_q && valid_i && !start_i;
  assign last_take_o = take_o && last_i;
  assign armed_o     = armed_q;

  always_comb begin
    if (!armed_q)                region_o = RG_NONE;
    else if (idx_q < IDX_DATA_END) region_o = RG_DATA;
    else if (idx_q < IDX_END)      region_o = RG_PARITY;
    else                           region_o = RG_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      idx_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      armed_q <= (32'(dec_err_i) > LIMIT);
      idx_q   <= '0;
    end else if (take_o) begin
      if (idx_q != IDX_END) idx_q <= idx_q + 1'b1;
      if (last_i) busy_q <= 1'b0;
    end
  end

  // R1: the byte index never runs past the end of the parity region
  p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_END);

endmodule

// File: rtl/esd_zero_accum.sv
module esd_zero_accum
  import esd_pkg::*;
#(
  parameter int LIMIT = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             add_en_i,
  input  logic [7:0]       byte_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam int unsigned CAP = LIMIT + 1;

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o      = cnt_q;
  assign cnt_next_o = add_en_i
                    ? CNT_W'(sat_add(32'(cnt_q), zero_bits(byte_i), CAP))
                    : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_next_o;
  end

  // R3: a region total never passes limit plus one
  p_sat_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= CAP);

  // R2: between clears a total only grows
  p_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/esd_verdict.sv
module esd_verdict #(
  parameter int LIMIT = 8,
  parameter int CNT_W = 4,
  parameter int SUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] dcnt_i,
  input  logic [CNT_W-1:0] pcnt_i,
  output logic             done_o,
  output logic             erased_o,
  output logic             uncorr_o,
  output logic             force_o,
  output logic [SUM_W-1:0] flips_o
);
  localparam logic [SUM_W-1:0] LIM = SUM_W'(LIMIT);

  logic [SUM_W-1:0] sum;
  logic             fits;

  assign sum  = SUM_W'(dcnt_i) + SUM_W'(pcnt_i);
  assign fits = (sum <= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      erased_o <= 1'b0;
      uncorr_o <= 1'b0;
      force_o  <= 1'b0;
      flips_o  <= '0;
    end else if (clear_i) begin
      done_o   <= 1'b0;
      erased_o <= 1'b0;
      uncorr_o <= 1'b0;
      force_o  <= 1'b0;
      flips_o  <= '0;
    end else if (load_i) begin
      done_o   <= 1'b1;
      erased_o <= armed_i && fits;
      uncorr_o <= armed_i && !fits;
      force_o  <= armed_i && fits && (dcnt_i != '0);
      flips_o  <= (armed_i && fits) ? sum : '0;
    end else begin
      done_o   <= 1'b0;
    end
  end

  // R4/R5: the two outcomes exclude each other
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(erased_o && uncorr_o));

  // R6: an all-ones rewrite is only asked for an erased sector
  p_force_erased_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_o |-> erased_o);

  // R4: an erased count stays within the correction limit
  p_count_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erased_o |-> flips_o <= LIM);

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/erased_sector_detect.sv
module erased_sector_detect
  import esd_pkg::*;
#(
  parameter int DATA_BYTES   = 512,
  parameter int PARITY_BYTES = 13,
  parameter int LIMIT        = 8,
  parameter int ERR_W        = 4,
  parameter int CNT_W        = $clog2(LIMIT + 2),
  parameter int SUM_W        = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ERR_W-1:0] dec_err_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_last_i,
  output logic             done_o,
  output logic             erased_o,
  output logic             uncorrectable_o,
  output logic             force_ones_o,
  output logic [SUM_W-1:0] flips_o
);
  localparam int NREG = 2;

  region_e          region;
  logic             take, last_take, armed;
  logic [CNT_W-1:0] cnt      [NREG];
  logic [CNT_W-1:0] cnt_next [NREG];

  esd_sequencer #(
    .DATA_BYTES  (DATA_BYTES),
    .PARITY_BYTES(PARITY_BYTES),
    .ERR_W       (ERR_W),
    .LIMIT       (LIMIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dec_err_i  (dec_err_i),
    .valid_i    (byte_valid_i),
    .last_i     (byte_last_i),
    .region_o   (region),
    .take_o     (take),
    .last_take_o(last_take),
    .armed_o    (armed)
  );

  // One saturating zero-bit total per region: index 0 data, index 1 parity.
  for (genvar g = 0; g < NREG; g++) begin : g_region
    localparam region_e MY_REGION = (g == 0) ? RG_DATA : RG_PARITY;
    logic add_en;
    assign add_en = take && (region == MY_REGION);

    esd_zero_accum #(
      .LIMIT(LIMIT),
      .CNT_W(CNT_W)
    ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start_i),
      .add_en_i  (add_en),
      .byte_i    (byte_i),
      .cnt_o     (cnt[g]),
      .cnt_next_o(cnt_next[g])
    );
  end

  esd_verdict #(
    .LIMIT(LIMIT),
    .CNT_W(CNT_W),
    .SUM_W(SUM_W)
  ) u_verdict (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .load_i  (last_take),
    .armed_i (armed),
    .dcnt_i  (cnt_next[0]),
    .pcnt_i  (cnt_next[1]),
    .done_o  (done_o),
    .erased_o(erased_o),
    .uncorr_o(uncorrectable_o),
    .force_o (force_ones_o),
    .flips_o (flips_o)
  );

  // R8: without a start or a final byte the verdict does not move
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !last_take)
      |=> $stable({erased_o, uncorrectable_o, force_ones_o, flips_o}));

  // R9: a start pulse leaves every output cleared in the next cycle
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !erased_o && !uncorrectable_o
                 && !force_ones_o && flips_o == '0));

endmodule

// File: tb/erased_sector_detect_test.sv
module erased_sector_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDATA      = 512;
  localparam int NPAR       = 13;
  localparam int NSEC       = NDATA + NPAR;
  localparam int CAP        = 9;
  localparam int BUF_LEN    = 600;

  typedef struct {
    bit          erased;
    bit          uncorr;
    bit          force1;
    int          flips;
    string       req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] dec_err_i = '0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_last_i = 1'b0;
  logic       done_o, erased_o, uncorrectable_o, force_ones_o;
  logic [4:0] flips_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   cycles   = 0;
  bit   prev_done = 1'b0;
  exp_t exp_q[$];
  exp_t last_exp;
  logic [7:0] sec [BUF_LEN];

  always #(CLK_PERIOD / 2) clk = ~clk;

  erased_sector_detect uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .dec_err_i      (dec_err_i),
    .byte_valid_i   (byte_valid_i),
    .byte_i         (byte_i),
    .byte_last_i    (byte_last_i),
    .done_o         (done_o),
    .erased_o       (erased_o),
    .uncorrectable_o(uncorrectable_o),
    .force_ones_o   (force_ones_o),
    .flips_o        (flips_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int zeros_in(input logic [7:0] b);
    int n = 0;
    for (int k = 0; k < 8; k++) n += (b[k] == 1'b0) ? 1 : 0;
    return n;
  endfunction

  task automatic fill_ones();
    for (int i = 0; i < BUF_LEN; i++) sec[i] = 8'hFF;
  endtask

  // Put n zero bits (1..8) into byte position pos.
  task automatic put_zeros(input int pos, input int n);
    sec[pos] = 8'hFF << n;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // Driver: computes the expected verdict, queues it, then streams bytes.
  task automatic run_sector(input int len, input int dec, input bit gaps,
                            input string req);
    exp_t e;
    int   d = 0;
    int   p = 0;
    bit   armed;
    armed = (dec > 8);
    for (int i = 0; i < len; i++) begin
      if (i < NDATA)     d = (d + zeros_in(sec[i]) > CAP) ? CAP : d + zeros_in(sec[i]);
      else if (i < NSEC) p = (p + zeros_in(sec[i]) > CAP) ? CAP : p + zeros_in(sec[i]);
    end
    e.req    = req;
    e.erased = armed && (d + p <= 8);
    e.uncorr = armed && (d + p > 8);
    e.force1 = e.erased && (d != 0);
    e.flips  = e.erased ? d + p : 0;
    exp_q.push_back(e);
    last_exp = e;

    @(negedge clk);
    start_i   = 1'b1;
    dec_err_i = 4'(dec);
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o && !erased_o && !uncorrectable_o && !force_ones_o && flips_o == 0,
          "R9", "outputs after start", int'(flips_o) + int'(erased_o), 0);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 100 == 50)) begin
        byte_valid_i = 1'b0;
        byte_i       = 8'h00;
        byte_last_i  = 1'b0;
        @(negedge clk);
      end
      byte_valid_i = 1'b1;
      byte_i       = sec[i];
      byte_last_i  = (i == len - 1);
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
    byte_last_i  = 1'b0;
    byte_i       = 8'h00;
  endtask

  // Check that the verdict holds while stray zero bytes arrive outside a sector.
  task automatic check_hold();
    for (int k = 0; k < 3; k++) begin
      byte_valid_i = 1'b1;
      byte_i       = 8'h00;
      byte_last_i  = (k == 2);
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
    byte_last_i  = 1'b0;
    @(negedge clk);
    check(erased_o == last_exp.erased && uncorrectable_o == last_exp.uncorr &&
          force_ones_o == last_exp.force1 && int'(flips_o) == last_exp.flips && !done_o,
          "R8", "verdict held", int'(flips_o), last_exp.flips);
  endtask

  // Monitor: pops the expected verdict on every done pulse and compares it.
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
        summary();
        $finish;
      end
      if (done_o) begin
        check(!prev_done, "R8", "done pulse width", 2, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(erased_o == e.erased, e.req, "erased", int'(erased_o), int'(e.erased));
          check(uncorrectable_o == e.uncorr, e.req, "uncorrectable",
                int'(uncorrectable_o), int'(e.uncorr));
          check(force_ones_o == e.force1, e.req, "force_ones",
                int'(force_ones_o), int'(e.force1));
          check(int'(flips_o) == e.flips, e.req, "flips", int'(flips_o), e.flips);
        end
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!done_o && !erased_o && !uncorrectable_o && !force_ones_o && flips_o == 0,
          "R10", "reset outputs", int'(flips_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: clean erased sector, zero flips
    fill_ones();
    run_sector(NSEC, 15, 1'b0, "R4");
    check_hold();

    // R6 and R1: zero bits at last data byte (511) and first parity byte (512)
    fill_ones();
    put_zeros(511, 3);
    put_zeros(512, 2);
    run_sector(NSEC, 12, 1'b0, "R6");

    // R6: zero bits only in parity, sum 8 boundary: no rewrite request
    fill_ones();
    put_zeros(515, 5);
    put_zeros(524, 3);
    run_sector(NSEC, 9, 1'b0, "R6");

    // R4: 8 zero bits all in data, spread over bytes, with idle cycles (R1)
    fill_ones();
    put_zeros(0, 1);
    put_zeros(60, 2);
    put_zeros(250, 1);
    put_zeros(400, 4);
    run_sector(NSEC, 10, 1'b1, "R4");

    // R5: sum of 9 is uncorrectable
    fill_ones();
    put_zeros(10, 5);
    put_zeros(520, 4);
    run_sector(NSEC, 13, 1'b0, "R5");
    check_hold();

    // R3: all-zero data saturates without wrapping (4096 zero bits)
    fill_ones();
    for (int i = 0; i < NDATA; i++) sec[i] = 8'h00;
    run_sector(NSEC, 15, 1'b0, "R3");

    // R3: all-zero parity saturates, data clean
    fill_ones();
    for (int i = NDATA; i < NSEC; i++) sec[i] = 8'h00;
    run_sector(NSEC, 15, 1'b0, "R3");

    // R1: zero bytes past index 524 are not counted
    fill_ones();
    for (int i = NSEC; i < NSEC + 20; i++) sec[i] = 8'h00;
    run_sector(NSEC + 20, 11, 1'b0, "R1");

    // R2: one zero bit per byte over eight bytes in data
    fill_ones();
    for (int i = 100; i < 108; i++) put_zeros(i, 1);
    run_sector(NSEC, 14, 1'b0, "R2");

    // R7: decoder count at the limit leaves the check unarmed
    fill_ones();
    for (int i = 0; i < 40; i++) sec[i] = 8'h00;
    run_sector(NSEC, 8, 1'b0, "R7");

    // R7: decoder count of zero, clean sector, still unarmed
    fill_ones();
    run_sector(NSEC, 0, 1'b0, "R7");
    check_hold();

    // R9: a sector cut short by start leaves nothing behind
    @(negedge clk);
    start_i   = 1'b1;
    dec_err_i = 4'd15;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      byte_valid_i = 1'b1;
      byte_i       = 8'h00;
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
    fill_ones();
    put_zeros(300, 1);
    run_sector(NSEC, 15, 1'b0, "R9");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule